// File: doc/BRIEF.md
# Auto-acknowledge transmit timing controller

This block sets the timing of the automatic acknowledgement that a low-rate 2.4 GHz radio receiver sends after it accepts a frame. It does no modulation, parsing, CRC checking or address filtering. Those results arrive already qualified as single-cycle flags: a start-of-frame delimiter has been seen, the frame has ended, the frame asks for an acknowledgement, and the frame is a data or command frame. A free-running microsecond tick sets the time base, and one symbol lasts 16 ticks.

In immediate mode the block counts a turnaround from the end of the frame and then strobes the start of the acknowledgement. The long turnaround is 12 symbols. The short one, picked by a configuration pin, is 2 symbols. In slotted mode the block stops 6 symbols after the frame and reports that it is waiting. An external trigger pin then sets the start: the controller synchronises the pin and honours only a rising edge seen while it waits. The acknowledgement starts a fixed 16 µs after that edge. The transmission ends when a done input is raised or when a programmable duration runs out, and the block then returns to listening.

Top module: `ack_timing_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in listening (`state_o`=0) with status invalid (`status_o`=7) and no pulse on `irq_end` or `ack_start`. Reset also clears the latched slotted and short-turnaround settings.
- R2: `sfd_det` in listening moves `state_o` to busy (1) on the next cycle. `sfd_det` in any other state has no effect.
- R3: `frame_end` while receiving raises `irq_end` for exactly one cycle, on the cycle after it.
- R4: A frame that has no ack request, or is not a data or command frame (`frame_ok`=0), returns the block to listening with `status_o`=0 in the cycle after `frame_end`.
- R5: In immediate mode with short turnaround off, `ack_start` pulses and `state_o` becomes 2 in the cycle after the 192nd tick (12 symbols of 16 ticks) that follows `frame_end`. During the turnaround `state_o` stays 1.
- R6: In immediate mode with short turnaround on, the same happens after the 32nd tick (2 symbols).
- R7: In slotted mode, `status_o` becomes 1 (success, waiting for trigger) after the 96th tick (6 symbols) that follows `frame_end`. `state_o` stays 1 and no ack starts by itself.
- R8: While waiting, a rising edge on `trig_pin` goes through a two-flop synchroniser and an edge detector, 3 clocks in all. `ack_start` then follows the 16th tick after that.
- R9: A trigger edge that arrives before the waiting state begins, including a level that is still high when waiting starts, is ignored.
- R10: `ack_start` is a one-cycle pulse on entry to `state_o`=2. The block returns to listening in the cycle after `ack_done`, or after the 176th tick (11 symbols) counted from `ack_start`.
- R11: `cfg_slotted` and `cfg_short_ta` are sampled when an ack-requesting frame ends. Later changes do not affect that acknowledgement.
- R12: For acknowledged frames in immediate mode, `status_o` is 0 from `frame_end`. Every status value holds until the next accepted `sfd_det`, which sets it to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle microsecond tick |
| sfd_det | input | 1 | Start-of-frame delimiter detected |
| frame_end | input | 1 | Last symbol of frame received |
| ack_req | input | 1 | Frame requests acknowledgement (valid with frame_end) |
| frame_ok | input | 1 | Frame is data or command type (valid with frame_end) |
| cfg_slotted | input | 1 | Slotted mode select |
| cfg_short_ta | input | 1 | Short turnaround select |
| trig_pin | input | 1 | Asynchronous ack trigger pin |
| ack_done | input | 1 | Ack transmission finished early |
| state_o | output | 2 | 0 listening, 1 busy receiving, 2 transmitting ack |
| status_o | output | 3 | 0 success, 1 success waiting for trigger, 7 invalid |
| irq_end | output | 1 | Frame-end interrupt pulse |
| ack_start | output | 1 | Start-ack-transmit strobe |

## Verification
On every cycle, the assertions check the reset state and the move from listening to busy on a delimiter. They also check that the interrupt and start strobes last one cycle and that the start strobe lines up with entry into transmit. Finally they check that the waiting status first appears while the block is busy, and that `ack_done` ends the transmission. The exact tick counts of each turnaround, trigger latency and ack duration under random tick spacing can only be shown by the bench scenarios. The same goes for the ignored early triggers and delimiters, and for the sampling of the configuration at frame end.

// File: rtl/ack_timing_ctrl.sv
module ack_timing_ctrl #(
  parameter int US_PER_SYM   = 16,
  parameter int LONG_TA_SYM  = 12,
  parameter int SHORT_TA_SYM = 2,
  parameter int SLOT_TA_SYM  = 6,
  parameter int TRIG_LAT_US  = 16,
  parameter int ACK_LEN_SYM  = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       sfd_det,
  input  logic       frame_end,
  input  logic       ack_req,
  input  logic       frame_ok,
  input  logic       cfg_slotted,
  input  logic       cfg_short_ta,
  input  logic       trig_pin,
  input  logic       ack_done,
  output logic [1:0] state_o,
  output logic [2:0] status_o,
  output logic       irq_end,
  output logic       ack_start
);
  localparam int LONG_US  = LONG_TA_SYM * US_PER_SYM;
  localparam int SHORT_US = SHORT_TA_SYM * US_PER_SYM;
  localparam int SLOT_US  = SLOT_TA_SYM * US_PER_SYM;
  localparam int ACK_US   = ACK_LEN_SYM * US_PER_SYM;
  localparam int MAX_A    = (LONG_US > ACK_US) ? LONG_US : ACK_US;
  localparam int MAX_B    = (SLOT_US > SHORT_US) ? SLOT_US : SHORT_US;
  localparam int MAX_C    = (MAX_B > TRIG_LAT_US) ? MAX_B : TRIG_LAT_US;
  localparam int MAX_US   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CW       = $clog2(MAX_US + 1);

  localparam logic [2:0] ST_OK   = 3'd0;
  localparam logic [2:0] ST_WAIT = 3'd1;
  localparam logic [2:0] ST_NONE = 3'd7;

  typedef enum logic [2:0] {F_LISTEN, F_RX, F_TURN, F_WAIT, F_LAT, F_TX} fsm_t;

  fsm_t          fsm;
  logic [CW-1:0] cnt, target;
  logic          slot_q, short_q;
  logic [2:0]    status_q;
  logic          irq_q, start_q;
  logic          trg_s1, trg_s2, trg_s3;
  logic          trg_rise, hit;

  assign trg_rise = trg_s2 & ~trg_s3;

  always_comb begin
    case (fsm)
      F_TURN:  target = slot_q ? CW'(SLOT_US) : (short_q ? CW'(SHORT_US) : CW'(LONG_US));
      F_LAT:   target = CW'(TRIG_LAT_US);
      F_TX:    target = CW'(ACK_US);
      default: target = CW'(MAX_US);
    endcase
  end

  assign hit = tick && (cnt == target - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      trg_s1 <= 1'b0;
      trg_s2 <= 1'b0;
      trg_s3 <= 1'b0;
    end else begin
      trg_s1 <= trig_pin;
      trg_s2 <= trg_s1;
      trg_s3 <= trg_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm      <= F_LISTEN;
      cnt      <= '0;
      slot_q   <= 1'b0;
      short_q  <= 1'b0;
      status_q <= ST_NONE;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      if (tick) cnt <= cnt + CW'(1);
      case (fsm)
        F_LISTEN: if (sfd_det) begin
          fsm      <= F_RX;
          status_q <= ST_NONE;
        end
        F_RX: if (frame_end) begin
          irq_q <= 1'b1;
          cnt   <= '0;
          if (ack_req && frame_ok) begin
            slot_q  <= cfg_slotted;
            short_q <= cfg_short_ta;
            fsm     <= F_TURN;
            if (!cfg_slotted) status_q <= ST_OK;
          end else begin
            fsm      <= F_LISTEN;
            status_q <= ST_OK;
          end
        end
        F_TURN: if (hit) begin
          cnt <= '0;
          if (slot_q) begin
            fsm      <= F_WAIT;
            status_q <= ST_WAIT;
          end else begin
            fsm     <= F_TX;
            start_q <= 1'b1;
          end
        end
        F_WAIT: if (trg_rise) begin
          fsm <= F_LAT;
          cnt <= '0;
        end
        F_LAT: if (hit) begin
          fsm     <= F_TX;
          start_q <= 1'b1;
          cnt     <= '0;
        end
        F_TX: if (ack_done || hit) fsm <= F_LISTEN;
        default: fsm <= F_LISTEN;
      endcase
    end
  end

  assign state_o   = (fsm == F_LISTEN) ? 2'd0 : (fsm == F_TX) ? 2'd2 : 2'd1;
  assign status_o  = status_q;
  assign irq_end   = irq_q;
  assign ack_start = start_q;
endmodule

module ack_timing_chk (
  input logic       clk,
  input logic       rst,
  input logic       sfd_det,
  input logic       ack_done,
  input logic [1:0] state_o,
  input logic [2:0] status_o,
  input logic       irq_end,
  input logic       ack_start
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (state_o == 2'd0 && status_o == 3'd7 && !irq_end && !ack_start)); // R1
  AST_SFD_ENTER: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd0 && sfd_det) |=> state_o == 2'd1); // R2
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst) irq_end |=> !irq_end); // R3
  AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst) ack_start |-> (state_o == 2'd2 && $past(state_o) != 2'd2)); // R10
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) ack_start |=> !ack_start); // R10
  AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) (status_o == 3'd1 && $past(status_o) != 3'd1) |-> state_o == 2'd1); // R7
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst) (state_o == 2'd2 && ack_done) |=> state_o == 2'd0); // R10
endmodule

bind ack_timing_ctrl ack_timing_chk u_chk (.*);

// File: tb/tb_ack_timing_ctrl.sv
module tb_ack_timing_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst, tick, sfd_det, frame_end, ack_req, frame_ok;
  logic cfg_slotted, cfg_short_ta, trig_pin, ack_done;
  logic [1:0] state_o;
  logic [2:0] status_o;
  logic irq_end, ack_start;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_timing_ctrl dut (.*);

  function automatic int due_ticks(input bit slot, input bit shrt);
    if (slot) return 6 * 16;
    return shrt ? 2 * 16 : 12 * 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    sfd_det = 0; frame_end = 0; ack_done = 0; tick = 0;
  endtask

  task automatic idle_inputs();
    tick = 0; sfd_det = 0; frame_end = 0; ack_req = 0; frame_ok = 0;
    cfg_slotted = 0; cfg_short_ta = 0; trig_pin = 0; ack_done = 0;
  endtask

  task automatic count_until(input bit want_wait, input int due, input string req, input bit sfd_noise);
    int n = 0;
    forever begin
      if (want_wait ? (status_o == 3'd1) : (ack_start == 1'b1)) begin
        chk(n == due, req, n, due);
        if (!want_wait) chk(state_o == 2'd2, "R10", state_o, 2);
        return;
      end
      chk(state_o == 2'd1 && !ack_start, req, state_o, 1);
      if (n >= due) begin
        chk(0, req, n, due);
        return;
      end
      tick = $urandom_range(0, 1);
      if (sfd_noise) sfd_det = $urandom_range(0, 1);
      if (tick) n++;
      @(posedge clk);
      @(negedge clk);
      sfd_det = 0; tick = 0;
    end
  endtask

  task automatic frame(input bit areq, input bit ok, input bit slot, input bit shrt,
                       input bit early_trig, input bit use_done);
    int n;
    cfg_slotted = slot; cfg_short_ta = shrt;
    sfd_det = 1;
    cyc();
    chk(state_o == 2'd1, "R2", state_o, 1);
    chk(status_o == 3'd7, "R12", status_o, 7);
    repeat ($urandom_range(1, 4)) cyc();
    frame_end = 1; ack_req = areq; frame_ok = ok;
    cyc();
    ack_req = 0; frame_ok = 0;
    cfg_slotted = $urandom_range(0, 1); cfg_short_ta = $urandom_range(0, 1);
    chk(irq_end == 1'b1, "R3", irq_end, 1);
    if (!(areq && ok)) begin
      chk(state_o == 2'd0 && status_o == 3'd0, "R4", {state_o, status_o}, 0);
      cyc();
      chk(irq_end == 1'b0, "R3", irq_end, 0);
      return;
    end
    if (!slot) begin
      chk(status_o == 3'd0, "R12", status_o, 0);
      count_until(0, due_ticks(0, shrt), shrt ? "R6 R11" : "R5 R11", 1'b1);
    end else begin
      if (early_trig) trig_pin = 1;
      count_until(1, due_ticks(1, shrt), "R7 R11", 1'b1);
      repeat (6) begin
        tick = $urandom_range(0, 1);
        cyc();
      end
      chk(state_o == 2'd1 && status_o == 3'd1 && !ack_start, "R9", state_o, 1);
      trig_pin = 0;
      repeat (3) cyc();
      trig_pin = 1;
      repeat (3) cyc();
      trig_pin = 0;
      count_until(0, 16, "R8", 1'b0);
    end
    n = 0;
    if (use_done) begin
      repeat ($urandom_range(0, 5)) begin
        chk(state_o == 2'd2, "R10", state_o, 2);
        cyc();
      end
      sfd_det = 1;
      ack_done = 1;
      cyc();
      chk(state_o == 2'd0, "R10", state_o, 0);
    end else begin
      forever begin
        if (state_o == 2'd0) break;
        if (n >= 176) break;
        tick = $urandom_range(0, 1);
        if (tick) n++;
        cyc();
      end
      chk(n == 176 && state_o == 2'd0, "R10", n, 176);
    end
    chk(status_o == (slot ? 3'd1 : 3'd0), "R12", status_o, slot ? 1 : 0);
    repeat (3) cyc();
    chk(status_o == (slot ? 3'd1 : 3'd0), "R12", status_o, slot ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    rst = 1;
    @(negedge clk);
    cfg_slotted = 1; cfg_short_ta = 1; trig_pin = 1;
    cyc();
    cyc();
    rst = 0;
    chk(state_o == 2'd0 && status_o == 3'd7 && !irq_end && !ack_start, "R1", {state_o, status_o}, 7);
    trig_pin = 0;
    frame_end = 1; ack_req = 1; frame_ok = 1;
    cyc();
    ack_req = 0; frame_ok = 0;
    chk(state_o == 2'd0 && !irq_end, "R2", state_o, 0);

    frame(1, 1, 0, 0, 0, 0);
    frame(1, 1, 0, 1, 0, 1);
    frame(0, 1, 0, 0, 0, 0);
    frame(1, 0, 1, 0, 0, 0);
    frame(1, 1, 1, 0, 1, 0);
    frame(1, 1, 1, 1, 0, 1);

    for (int i = 0; i < 30; i++) begin
      frame($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
            $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1));
      repeat ($urandom_range(0, 3)) cyc();
    end

    sfd_det = 1;
    cyc();
    frame_end = 1; ack_req = 1; frame_ok = 1;
    cyc();
    ack_req = 0; frame_ok = 0;
    repeat (5) begin tick = 1; cyc(); end
    rst = 1;
    cyc();
    rst = 0;
    chk(state_o == 2'd0 && status_o == 3'd7 && !ack_start, "R1", {state_o, status_o}, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule